// File: doc/BRIEF.md
# Data-Processing Second-Operand Shifter

This combinational block forms the second operand of a data-processing instruction and the carry bit that the shifter hands to the flag logic. It takes the 32-bit instruction word, the values already read from the two source registers (the one being shifted and the one that supplies a shift amount), and the current carry flag. It produces the operand and the shifter carry-out in the same cycle. Register reads, the ALU and the flag write-back are handled by the blocks around it.

Two operand forms are supported. The immediate form rotates an 8-bit constant right by an even amount. The register form applies one of four shift kinds (left logical, right logical, right arithmetic, rotate right) to the shifted register. The shift amount comes either from a 5-bit field of the instruction or from the low byte of the amount register. Several encodings carry special meaning: a zero immediate amount, a register amount of exactly 32 or more, and a rotate amount that is a nonzero multiple of 32.

Top module: `operand_shifter`

## Requirements
- R1: When instruction bit 25 is 1, the operand is bits 7:0 zero-extended and rotated right by twice the value of bits 11:8. The carry-out is the carry input when that rotation is zero, and operand bit 31 otherwise.
- R2: When bit 25 is 0, bits 6:5 select the shift kind (00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right). Bit 4 selects the amount source: 0 takes bits 11:7, and 1 takes bits 7:0 of the amount register.
- R3: Left logical by an instruction amount of 0 gives the shifted register unchanged and passes the carry input through. A nonzero amount n gives carry = register bit (32−n).
- R4: Right logical and right arithmetic by an instruction amount of 0 act as a shift by 32. Right logical gives 0, and right arithmetic gives bit 31 replicated; both give carry = register bit 31. A nonzero amount n gives carry = register bit (n−1).
- R5: Rotate right by an instruction amount of 0 rotates through the carry: the result is {carry input, register bits 31:1} and the carry-out is register bit 0. A nonzero amount n rotates by n with carry = register bit (n−1).
- R6: For any register-amount shift whose amount byte is 0, the register passes through unchanged and the carry-out equals the carry input.
- R7: Left and right logical by a register amount of exactly 32 give 0, with carry = register bit 0 (left) or bit 31 (right). Amounts of 33 to 255 give 0 with carry 0. Amounts of 1 to 31 shift normally.
- R8: Right arithmetic by a register amount of 32 or more fills the result with bit 31 and sets the carry to bit 31.
- R9: Rotate right by a register amount whose low 5 bits are zero but whose byte is nonzero leaves the register unchanged, with carry = bit 31. Any other nonzero amount rotates by its low 5 bits, with carry = result bit 31.
- R10: Bits 31:8 of the amount register have no effect on the operand or the carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instrWord | input | 32 | Data-processing instruction word |
| rmValue | input | 32 | Value of the register being shifted |
| rsValue | input | 32 | Value of the register supplying a shift amount |
| carryIn | input | 1 | Current carry flag |
| operandOut | output | 32 | Shifted or rotated second operand |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The embedded assertions check, for every input combination, several properties. A pass-through case returns the source unchanged with the carry input. Rotate-through-carry and pass-through are never selected together. Logical right shifts beyond 32 yield zero with carry zero. A plain rotate always reports its top result bit as the carry. The exact carry bit chosen for each amount is left to the bench, which compares every vector against its bit-step reference model. So are the boundary amounts 0, 1, 31, 32, 33 and 255 in each shift kind and amount source, and the insensitivity to the upper amount-register bits.

// File: rtl/shifter_pkg.sv
package shifter_pkg;
  parameter int WORD_W = 32;
  localparam int AMT_W   = $clog2(WORD_W) + 1;
  localparam int ROT_W   = AMT_W - 1;
  localparam int AMT_MAX = (1 << AMT_W) - 1;
  localparam int BYTE_W  = 8;

  localparam int POS_IMM_FORM = 25;
  localparam int POS_REG_AMT  = 4;
  localparam int POS_TYPE_LO  = 5;
  localparam int POS_AMT_LO   = 7;
  localparam int POS_ROT_LO   = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shType_e;

  typedef struct packed {
    logic             srcImm;
    logic             passCarry;
    logic             rotExtend;
    shType_e          shType;
    logic [AMT_W-1:0] amount;
  } shCtrl_t;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
(
  input  logic [WORD_W-1:0] instrWord,
  input  logic [WORD_W-1:0] rsValue,
  output shCtrl_t           ctrl,
  output logic [WORD_W-1:0] immValue
);
  logic             isImmForm;
  logic             regAmtSel;
  shType_e          fieldType;
  logic [4:0]       instAmt;
  logic [3:0]       rotField;
  logic [BYTE_W-1:0] amtByte;
  logic             unusedBits;

  assign isImmForm = instrWord[POS_IMM_FORM];
  assign regAmtSel = instrWord[POS_REG_AMT];
  assign fieldType = shType_e'(instrWord[POS_TYPE_LO +: 2]);
  assign instAmt   = instrWord[POS_AMT_LO +: 5];
  assign rotField  = instrWord[POS_ROT_LO +: 4];
  assign amtByte   = rsValue[BYTE_W-1:0];
  assign immValue  = {{(WORD_W-8){1'b0}}, instrWord[7:0]};
  assign unusedBits = ^{instrWord[WORD_W-1:POS_IMM_FORM+1],
                        instrWord[POS_IMM_FORM-1:12],
                        rsValue[WORD_W-1:BYTE_W]};

  always_comb begin
    ctrl = '0;
    if (isImmForm) begin
      ctrl.srcImm    = 1'b1;
      ctrl.shType    = SH_ROR;
      ctrl.amount    = AMT_W'({rotField, 1'b0});
      ctrl.passCarry = (rotField == 4'd0);
    end else if (regAmtSel) begin
      ctrl.shType    = fieldType;
      ctrl.passCarry = (amtByte == '0);
      if (fieldType == SH_ROR)
        ctrl.amount = AMT_W'(amtByte[ROT_W-1:0]);
      else if (amtByte > BYTE_W'(AMT_MAX))
        ctrl.amount = AMT_W'(AMT_MAX);
      else
        ctrl.amount = AMT_W'(amtByte);
    end else begin
      ctrl.shType = fieldType;
      if (instAmt == 5'd0) begin
        case (fieldType)
          SH_LSL:  ctrl.passCarry = 1'b1;
          SH_ROR:  ctrl.rotExtend = 1'b1;
          default: ctrl.amount    = AMT_W'(WORD_W);
        endcase
      end else begin
        ctrl.amount = AMT_W'(instAmt);
      end
    end
  end

  always_comb begin
    p_single_special_r6: assert ($onehot0({ctrl.passCarry, ctrl.rotExtend}))
      else $error("pass-through and rotate-extend both selected");
    if (ctrl.rotExtend) begin
      p_rrx_only_inst_amt_r5: assert (!isImmForm && !regAmtSel && instAmt == 5'd0)
        else $error("rotate-extend outside zero instruction amount");
    end
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
(
  input  shCtrl_t           ctrl,
  input  logic [WORD_W-1:0] immValue,
  input  logic [WORD_W-1:0] rmValue,
  input  logic              carryIn,
  output logic [WORD_W-1:0] operandOut,
  output logic              carryOut
);
  logic [WORD_W-1:0]          srcVal;
  logic [2*WORD_W-1:0]        rotDouble;
  logic [WORD_W-1:0]          rotRes;
  logic [WORD_W:0]            leftExt;
  logic signed [WORD_W+1:0]   rightIn;
  logic signed [WORD_W+1:0]   rightExt;
  logic                       fillBit;
  logic                       unusedBits;

  assign srcVal    = ctrl.srcImm ? immValue : rmValue;
  assign rotDouble = {srcVal, srcVal} >> ctrl.amount[ROT_W-1:0];
  assign rotRes    = rotDouble[WORD_W-1:0];
  assign leftExt   = {1'b0, srcVal} << ctrl.amount;
  assign fillBit   = (ctrl.shType == SH_ASR) && srcVal[WORD_W-1];
  assign rightIn   = $signed({fillBit, srcVal, 1'b0});
  assign rightExt  = rightIn >>> ctrl.amount;
  assign unusedBits = ^{rotDouble[2*WORD_W-1:WORD_W], rightExt[WORD_W+1]};

  always_comb begin
    if (ctrl.passCarry) begin
      operandOut = srcVal;
      carryOut   = carryIn;
    end else if (ctrl.rotExtend) begin
      operandOut = {carryIn, srcVal[WORD_W-1:1]};
      carryOut   = srcVal[0];
    end else begin
      case (ctrl.shType)
        SH_LSL: begin
          operandOut = leftExt[WORD_W-1:0];
          carryOut   = leftExt[WORD_W];
        end
        SH_ROR: begin
          operandOut = rotRes;
          carryOut   = rotRes[WORD_W-1];
        end
        default: begin
          operandOut = rightExt[WORD_W:1];
          carryOut   = rightExt[0];
        end
      endcase
    end
  end

  always_comb begin
    if (ctrl.passCarry) begin
      p_pass_keeps_carry_r6: assert (carryOut == carryIn && operandOut == srcVal)
        else $error("pass-through altered operand or carry");
    end
    if (!ctrl.passCarry && ctrl.shType == SH_LSR && ctrl.amount > AMT_W'(WORD_W)) begin
      p_lsr_far_zero_r7: assert (operandOut == '0 && !carryOut)
        else $error("logical right beyond width not zero");
    end
    if (!ctrl.passCarry && ctrl.shType == SH_ASR) begin
      p_asr_keeps_sign_r8: assert (operandOut[WORD_W-1] == rmValue[WORD_W-1])
        else $error("arithmetic right lost sign");
    end
    if (!ctrl.passCarry && !ctrl.rotExtend && ctrl.shType == SH_ROR) begin
      p_ror_carry_top_r9: assert (carryOut == operandOut[WORD_W-1])
        else $error("rotate carry differs from top bit");
    end
  end
endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
  import shifter_pkg::*;
(
  input  logic [31:0] instrWord,
  input  logic [31:0] rmValue,
  input  logic [31:0] rsValue,
  input  logic        carryIn,
  output logic [31:0] operandOut,
  output logic        carryOut
);
  shCtrl_t           shCtrl;
  logic [WORD_W-1:0] immValue;

  shift_ctrl u_ctrl (
    .instrWord (instrWord),
    .rsValue   (rsValue),
    .ctrl      (shCtrl),
    .immValue  (immValue)
  );

  shift_datapath u_dp (
    .ctrl       (shCtrl),
    .immValue   (immValue),
    .rmValue    (rmValue),
    .carryIn    (carryIn),
    .operandOut (operandOut),
    .carryOut   (carryOut)
  );
endmodule

// File: tb/tb_operand_shifter.sv
module tb_operand_shifter;
  logic        clk = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] rmValue = '0;
  logic [31:0] rsValue = '0;
  logic        carryIn = 1'b0;
  logic [31:0] operandOut;
  logic        carryOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  operand_shifter dut (
    .instrWord(instrWord), .rmValue(rmValue), .rsValue(rsValue),
    .carryIn(carryIn), .operandOut(operandOut), .carryOut(carryOut)
  );

  function automatic void refModel(input logic [31:0] ir, rm, rs, input logic c,
                                   output logic [31:0] op, output logic co);
    logic [31:0] v;
    int k;
    bit rsel;
    v = rm; co = c;
    if (ir[25]) begin
      v = {24'b0, ir[7:0]};
      k = 2 * int'(ir[11:8]);
      for (int i = 0; i < k; i++) v = {v[0], v[31:1]};
      if (k != 0) co = v[31];
      op = v;
      return;
    end
    rsel = ir[4];
    k = rsel ? int'(rs[7:0]) : int'(ir[11:7]);
    if (rsel && k == 0) begin op = rm; co = c; return; end
    case (ir[6:5])
      2'd0: for (int i = 0; i < k; i++) begin co = v[31]; v = v << 1; end
      2'd1: begin
        if (!rsel && k == 0) k = 32;
        for (int i = 0; i < k; i++) begin co = v[0]; v = v >> 1; end
      end
      2'd2: begin
        if (!rsel && k == 0) k = 32;
        for (int i = 0; i < k; i++) begin co = v[0]; v = {v[31], v[31:1]}; end
      end
      default: begin
        if (!rsel && k == 0) begin co = v[0]; v = {c, v[31:1]}; end
        else if (rsel && (k % 32) == 0) co = v[31];
        else for (int i = 0; i < k % 32; i++) begin co = v[0]; v = {v[0], v[31:1]}; end
      end
    endcase
    op = v;
  endfunction

  function automatic string tagOf(input logic [31:0] ir, rs);
    if (ir[25]) return "R1";
    if (ir[4]) begin
      if (rs[7:0] == 0) return "R6";
      case (ir[6:5]) 2'd0, 2'd1: return "R7"; 2'd2: return "R8"; default: return "R9"; endcase
    end
    case (ir[6:5]) 2'd0: return "R3"; 2'd3: return "R5"; default: return "R4"; endcase
  endfunction

  task automatic apply(input logic [31:0] ir, rm, rs, input logic c, input string tag);
    logic [31:0] expOp;
    logic expC;
    @(posedge clk);
    instrWord = ir; rmValue = rm; rsValue = rs; carryIn = c;
    refModel(ir, rm, rs, c, expOp, expC);
    @(negedge clk);
    nChecks++;
    if (operandOut !== expOp || carryOut !== expC) begin
      nFails++;
      $display("FAIL %s ir=%08h rm=%08h rs=%08h c=%0b actual=%08h/%0b expected=%08h/%0b",
               tag, ir, rm, rs, c, operandOut, carryOut, expOp, expC);
    end
  endtask

  function automatic logic [31:0] encInst(input int kind, input int amt, input bit rsel);
    return 32'hE1B0_0000 | (32'(amt & 31) << 7) | (32'(kind) << 5) | (32'(rsel) << 4) | 32'h2;
  endfunction

  initial begin
    logic [31:0] pats [5] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_3C3C, 32'h0, 32'hFFFF_FFFF};
    int regAmts [8] = '{0, 1, 31, 32, 33, 255, 64, 40};
    int instAmts [4] = '{0, 1, 31, 16};
    // R1: immediate rotate, every rotation field
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 2; c++) begin
        apply(32'hE3B0_0000 | (32'(r) << 8) | 32'h81, 32'h0, 32'h0, c[0], "R1");
        apply(32'hE3B0_0000 | (32'(r) << 8) | 32'h7E, 32'h0, 32'h0, c[0], "R1");
      end
    // R3 R4 R5: instruction amounts; R6 R7 R8 R9: register amounts
    for (int kind = 0; kind < 4; kind++)
      for (int p = 0; p < 5; p++)
        for (int c = 0; c < 2; c++) begin
          foreach (instAmts[a]) apply(encInst(kind, instAmts[a], 1'b0), pats[p], 32'h0, c[0],
                                      tagOf(encInst(kind, instAmts[a], 1'b0), 32'h0));
          foreach (regAmts[a]) apply(encInst(kind, 0, 1'b1), pats[p], 32'(regAmts[a]), c[0],
                                     tagOf(encInst(kind, 0, 1'b1), 32'(regAmts[a])));
        end
    // R10: upper amount-register bits must not matter
    for (int kind = 0; kind < 4; kind++)
      foreach (regAmts[a]) apply(encInst(kind, 0, 1'b1), 32'hC3A5_0F81,
                                 32'hDEAD_BE00 | 32'(regAmts[a]), 1'b1, "R10");
    // R2: random sweep of field selection
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ir, rs;
      ir = $urandom;
      rs = $urandom;
      if (n % 3 == 0) rs[7:0] = 8'($urandom_range(0, 40));
      if (!ir[25]) ir[7] = ir[4] ? 1'b0 : ir[7];
      apply(ir, $urandom, rs, 1'($urandom), "R2");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule